// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Chain

This block holds the digital side of an integer-channel frequency synthesizer. A feedback divider built from a 32/33 dual-modulus prescaler, a main counter and a swallow counter divides the oscillator-rate tick stream by 32·SMC + SSC. SMC is 40 plus a 3-bit main code, so it runs from 40 to 47. SSC is a 5-bit swallow code from 0 to 31. A reference divider divides the reference tick stream by 3, 4, 6 or 8. Both divided pulse trains feed a digital lock detector and a test selector that drives a single lock/test output pin and a charge-pump tristate flag.

The block runs on one fast clock. Oscillator and reference edges arrive as one-cycle tick enables. The divide codes are sampled only at the start of each divided period. A new channel therefore takes effect on the next boundary, and the period in flight is never cut short.

Top module: `pll_div_chain`

## Requirements
- R1: `fb_pulse_o` is a one-cycle pulse. It is issued once every 32·(40+`main_code_i`)+`swallow_code_i` cycles in which `vco_en_i` is high. It appears in the cycle after the edge that takes the last tick of the period. The first period starts with the first tick after reset.
- R2: The main and swallow codes are sampled at the first tick of each feedback period. A change made during a period has no effect on that period's length and governs the next period.
- R3: `ref_pulse_o` is a one-cycle pulse every N cycles with `ref_en_i` high. N is 3, 4, 6 or 8 for `ref_code_i` 00, 01, 10 or 11. The code is sampled at the first tick of each reference period.
- R4: Cycles with `vco_en_i` low do not advance the feedback divider. Cycles with `ref_en_i` low do not advance the reference divider.
- R5: A reference pulse is a hit if a feedback pulse occurs no more than 4 clock cycles before it, in the same cycle, or no more than 4 cycles after it. It is a miss if no feedback pulse comes within 4 cycles after it, or if the next reference pulse arrives first.
- R6: The lock flag becomes 1 after 16 consecutive hits and stays 1 while hits continue.
- R7: A single miss clears the lock flag at once and restarts the count of hits.
- R8: With `test_code_i` 000, `ld_o` shows the lock flag. With 001 it shows a toggle that flips on each feedback pulse. With 010 it shows a toggle that flips on each reference pulse. With 011 it shows the reference pulse count divided by 512. For all four, `cp_hiz_o` is 0.
- R9: Codes 100, 101 and 110 show the same signals as 000, 001 and 010. Code 111 shows `ref_pulse_o` undivided. For all four, `cp_hiz_o` is 1.
- R10: While `rst_ni` is low, `fb_pulse_o`, `ref_pulse_o` and the lock flag are 0. The toggles and the reference count also clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vco_en_i | input | 1 | One tick per oscillator-rate edge |
| ref_en_i | input | 1 | One tick per reference edge |
| main_code_i | input | 3 | Main counter code, SMC = 40 + code |
| swallow_code_i | input | 5 | Swallow count SSC |
| ref_code_i | input | 2 | Reference ratio select |
| test_code_i | input | 3 | Lock/test output select |
| fb_pulse_o | output | 1 | Divided feedback pulse |
| ref_pulse_o | output | 1 | Divided reference pulse |
| ld_o | output | 1 | Lock or test signal |
| cp_hiz_o | output | 1 | Charge pump forced high-impedance |

## Verification
The feedback divider runs first with a steady tick stream at a ratio of 1281. It is then run with a main and swallow change made mid-period, which separates boundary sampling from immediate use. The lock detector is driven with reference trains placed 1, 11, 4, 5 and −4 cycles from the feedback pulse. This sets apart a hit at the window edge from a miss one cycle beyond it, on both sides. The test selector and the reference ratios are tried with a reference tick in every cycle, which makes the divide-by-512 toggle visible. A pseudo-random gating of both tick inputs shows that only enabled cycles advance the counters.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  localparam int unsigned REF_RATIO_MAX = 8;

  typedef enum logic [2:0] {
    TM_LOCK    = 3'd0,
    TM_FB2     = 3'd1,
    TM_REF2    = 3'd2,
    TM_REF512  = 3'd3,
    TM_LOCK_Z  = 3'd4,
    TM_FB2_Z   = 3'd5,
    TM_REF2_Z  = 3'd6,
    TM_REF_Z   = 3'd7
  } test_sel_e;

  // ratio minus one, for 3/4/6/8
  function automatic logic [2:0] ref_limit(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/pll_fb_div.sv
module pll_fb_div #(
  parameter int unsigned PRESC_W   = 5,
  parameter int unsigned MAIN_W    = 3,
  parameter int unsigned MAIN_BASE = 40,
  parameter int unsigned SWAL_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vco_en_i,
  input  logic [MAIN_W-1:0] main_code_i,
  input  logic [SWAL_W-1:0] swallow_code_i,
  output logic              pulse_o
);

  localparam int unsigned PRESC_MOD = 2 ** PRESC_W;
  localparam int unsigned CNT_W     = PRESC_W + 1;
  localparam int unsigned SMC_MAX   = MAIN_BASE + 2 ** MAIN_W - 1;
  localparam int unsigned IDX_W     = $clog2(SMC_MAX + 1);
  localparam int unsigned CMP_W     = (IDX_W > SWAL_W) ? IDX_W : SWAL_W;

  logic [CNT_W-1:0]  presc_q;
  logic [IDX_W-1:0]  idx_q, smc_q, cur_smc;
  logic [SWAL_W-1:0] ssc_q, cur_ssc;
  logic              start, mod33, presc_last, period_last, pulse_q;

  assign start       = (presc_q == '0) && (idx_q == '0);
  assign cur_smc     = start ? IDX_W'(MAIN_BASE) + IDX_W'(main_code_i) : smc_q;
  assign cur_ssc     = start ? swallow_code_i : ssc_q;
  // divide by 33 while swallow periods remain
  assign mod33       = CMP_W'(idx_q) < CMP_W'(cur_ssc);
  assign presc_last  = presc_q == (mod33 ? CNT_W'(PRESC_MOD) : CNT_W'(PRESC_MOD - 1));
  assign period_last = presc_last && (idx_q == cur_smc - IDX_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      idx_q   <= '0;
      smc_q   <= IDX_W'(MAIN_BASE);
      ssc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= vco_en_i && period_last;
      if (vco_en_i) begin
        if (start) begin
          smc_q <= cur_smc;
          ssc_q <= cur_ssc;
        end
        if (presc_last) begin
          presc_q <= '0;
          idx_q   <= period_last ? '0 : idx_q + IDX_W'(1);
        end else begin
          presc_q <= presc_q + CNT_W'(1);
        end
      end
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div
  import pll_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_en_i,
  input  logic [1:0] ref_code_i,
  output logic       pulse_o
);

  localparam int unsigned CNT_W = $clog2(REF_RATIO_MAX);

  logic [CNT_W-1:0] cnt_q, lim_q, cur_lim;
  logic             start, last, pulse_q;

  assign start   = cnt_q == '0;
  assign cur_lim = start ? CNT_W'(ref_limit(ref_code_i)) : lim_q;
  assign last    = cnt_q == cur_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= ref_en_i && last;
      if (ref_en_i) begin
        if (start) lim_q <= cur_lim;
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int unsigned WIN    = 4,
  parameter int unsigned LOCK_N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fb_pulse_i,
  input  logic ref_pulse_i,
  output logic lock_o
);

  localparam int unsigned SINCE_W = $clog2(WIN + 1);
  localparam int unsigned WAIT_W  = (WIN > 2) ? $clog2(WIN) : 1;
  localparam int unsigned HIT_W   = $clog2(LOCK_N + 1);

  logic [SINCE_W-1:0] since_q;
  logic [WAIT_W-1:0]  wcnt_q, wcnt_d;
  logic [HIT_W-1:0]   hits_q;
  logic               wait_q, wait_d, hit, miss;

  always_comb begin
    hit    = 1'b0;
    miss   = 1'b0;
    wait_d = wait_q;
    wcnt_d = wcnt_q;
    if (ref_pulse_i) begin
      if (wait_q && !fb_pulse_i) begin
        // previous reference never matched
        miss   = 1'b1;
        wait_d = 1'b1;
        wcnt_d = '0;
      end else if (fb_pulse_i || (since_q < SINCE_W'(WIN))) begin
        hit    = 1'b1;
        wait_d = 1'b0;
      end else begin
        wait_d = 1'b1;
        wcnt_d = '0;
      end
    end else if (wait_q) begin
      if (fb_pulse_i) begin
        hit    = 1'b1;
        wait_d = 1'b0;
      end else if (wcnt_q == WAIT_W'(WIN - 1)) begin
        miss   = 1'b1;
        wait_d = 1'b0;
      end else begin
        wcnt_d = wcnt_q + WAIT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= SINCE_W'(WIN);
      wcnt_q  <= '0;
      wait_q  <= 1'b0;
      hits_q  <= '0;
    end else begin
      wait_q <= wait_d;
      wcnt_q <= wcnt_d;
      if (fb_pulse_i)                    since_q <= '0;
      else if (since_q != SINCE_W'(WIN)) since_q <= since_q + SINCE_W'(1);
      if (miss)                                   hits_q <= '0;
      else if (hit && (hits_q != HIT_W'(LOCK_N))) hits_q <= hits_q + HIT_W'(1);
    end
  end

  assign lock_o = hits_q == HIT_W'(LOCK_N);

endmodule

// File: rtl/pll_test_mux.sv
module pll_test_mux
  import pll_div_pkg::*;
#(
  parameter int unsigned DIV_W = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fb_pulse_i,
  input  logic       ref_pulse_i,
  input  logic       lock_i,
  input  logic [2:0] test_code_i,
  output logic       ld_o,
  output logic       cp_hiz_o
);

  logic [DIV_W-1:0] ref_cnt_q;
  logic             fb_tog_q;
  test_sel_e        sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cnt_q <= '0;
      fb_tog_q  <= 1'b0;
    end else begin
      if (ref_pulse_i) ref_cnt_q <= ref_cnt_q + DIV_W'(1);
      if (fb_pulse_i)  fb_tog_q  <= ~fb_tog_q;
    end
  end

  assign sel = test_sel_e'(test_code_i);

  always_comb begin
    case (sel)
      TM_LOCK, TM_LOCK_Z: ld_o = lock_i;
      TM_FB2, TM_FB2_Z:   ld_o = fb_tog_q;
      TM_REF2, TM_REF2_Z: ld_o = ref_cnt_q[0];
      TM_REF512:          ld_o = ref_cnt_q[DIV_W-1];
      default:            ld_o = ref_pulse_i;
    endcase
  end

  assign cp_hiz_o = test_code_i[2];

endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int unsigned PRESC_W   = 5,
  parameter int unsigned MAIN_W    = 3,
  parameter int unsigned MAIN_BASE = 40,
  parameter int unsigned SWAL_W    = 5,
  parameter int unsigned LOCK_WIN  = 4,
  parameter int unsigned LOCK_N    = 16,
  parameter int unsigned TEST_DIV_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vco_en_i,
  input  logic              ref_en_i,
  input  logic [MAIN_W-1:0] main_code_i,
  input  logic [SWAL_W-1:0] swallow_code_i,
  input  logic [1:0]        ref_code_i,
  input  logic [2:0]        test_code_i,
  output logic              fb_pulse_o,
  output logic              ref_pulse_o,
  output logic              ld_o,
  output logic              cp_hiz_o
);

  logic lock;

  pll_fb_div #(
    .PRESC_W  (PRESC_W),
    .MAIN_W   (MAIN_W),
    .MAIN_BASE(MAIN_BASE),
    .SWAL_W   (SWAL_W)
  ) i_fb_div (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vco_en_i      (vco_en_i),
    .main_code_i   (main_code_i),
    .swallow_code_i(swallow_code_i),
    .pulse_o       (fb_pulse_o)
  );

  pll_ref_div i_ref_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_en_i  (ref_en_i),
    .ref_code_i(ref_code_i),
    .pulse_o   (ref_pulse_o)
  );

  pll_lock_det #(
    .WIN   (LOCK_WIN),
    .LOCK_N(LOCK_N)
  ) i_lock_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fb_pulse_i (fb_pulse_o),
    .ref_pulse_i(ref_pulse_o),
    .lock_o     (lock)
  );

  pll_test_mux #(
    .DIV_W(TEST_DIV_W)
  ) i_test_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fb_pulse_i (fb_pulse_o),
    .ref_pulse_i(ref_pulse_o),
    .lock_i     (lock),
    .test_code_i(test_code_i),
    .ld_o       (ld_o),
    .cp_hiz_o   (cp_hiz_o)
  );

endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk #(
  parameter int unsigned PRESC_W   = 5,
  parameter int unsigned MAIN_W    = 3,
  parameter int unsigned MAIN_BASE = 40,
  parameter int unsigned SWAL_W    = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vco_en_i,
  input logic       ref_en_i,
  input logic [2:0] test_code_i,
  input logic       fb_pulse_o,
  input logic       ref_pulse_o,
  input logic       ld_o
);

  localparam int unsigned SMC_MAX = MAIN_BASE + 2 ** MAIN_W - 1;
  localparam int unsigned R_MIN   = (2 ** PRESC_W) * MAIN_BASE;
  localparam int unsigned R_MAX   = (2 ** PRESC_W + 1) * SMC_MAX;
  localparam int unsigned TW      = $clog2(R_MAX + 1) + 1;

  logic [TW-1:0] ticks_q;

  // ticks taken since the last feedback pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ticks_q <= '0;
    else if (fb_pulse_o) ticks_q <= TW'(vco_en_i);
    else if (vco_en_i && (ticks_q != '1)) ticks_q <= ticks_q + TW'(1);
  end

  p_fb_ratio_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> (ticks_q >= TW'(R_MIN)) && (ticks_q <= TW'(R_MAX)));

  p_fb_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o);

  p_fb_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> $past(vco_en_i));

  p_ref_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> $past(ref_en_i));

  p_ref_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);

  p_lock_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ld_o) && (test_code_i == 3'd0) && ($past(test_code_i) == 3'd0))
      |-> $past(fb_pulse_o || ref_pulse_o));

endmodule

bind pll_div_chain pll_div_chain_chk #(
  .PRESC_W  (PRESC_W),
  .MAIN_W   (MAIN_W),
  .MAIN_BASE(MAIN_BASE),
  .SWAL_W   (SWAL_W)
) i_chk (.*);

// File: tb/test_pll_div_chain.sv
`timescale 1ns/1ps
module test_pll_div_chain;

  localparam int WIN = 4;
  localparam int LOCKN = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vco_en_i = 1'b0, ref_en_i = 1'b0;
  logic [2:0] main_code_i = '0;
  logic [4:0] swallow_code_i = '0;
  logic [1:0] ref_code_i = '0;
  logic [2:0] test_code_i = '0;
  logic       fb_pulse_o, ref_pulse_o, ld_o, cp_hiz_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pll_div_chain i_pll_div_chain (
    .clk_i(clk), .rst_ni(rst_ni), .vco_en_i(vco_en_i), .ref_en_i(ref_en_i),
    .main_code_i(main_code_i), .swallow_code_i(swallow_code_i),
    .ref_code_i(ref_code_i), .test_code_i(test_code_i),
    .fb_pulse_o(fb_pulse_o), .ref_pulse_o(ref_pulse_o),
    .ld_o(ld_o), .cp_hiz_o(cp_hiz_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int fb_tick, fb_len, ref_tick, ref_len, since, wk, hits, rcnt;
  bit fb_e, ref_e, waiting, ftog;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_tick = 0; fb_len = 0; ref_tick = 0; ref_len = 0;
      since = WIN; wk = 0; hits = 0; rcnt = 0;
      fb_e = 0; ref_e = 0; waiting = 0; ftog = 0;
    end else begin
      bit hit, miss;
      hit = 0; miss = 0;
      if (ref_e) begin
        if (waiting && !fb_e) begin miss = 1; wk = 0; end
        else if (fb_e || since < WIN) begin hit = 1; waiting = 0; end
        else begin waiting = 1; wk = 0; end
      end else if (waiting) begin
        if (fb_e) begin hit = 1; waiting = 0; end
        else if (wk == WIN - 1) begin miss = 1; waiting = 0; end
        else wk++;
      end
      since = fb_e ? 0 : (since < WIN ? since + 1 : WIN);
      if (miss) hits = 0;
      else if (hit && hits < LOCKN) hits++;
      if (ref_e) rcnt = (rcnt + 1) % 512;
      if (fb_e) ftog = !ftog;
      fb_e = 0;
      if (vco_en_i) begin
        if (fb_tick == 0) fb_len = 32 * (40 + int'(main_code_i)) + int'(swallow_code_i);
        fb_tick++;
        if (fb_tick == fb_len) begin fb_e = 1; fb_tick = 0; end
      end
      ref_e = 0;
      if (ref_en_i) begin
        if (ref_tick == 0) ref_len = (ref_code_i == 0) ? 3 : (ref_code_i == 1) ? 4 :
                                     (ref_code_i == 2) ? 6 : 8;
        ref_tick++;
        if (ref_tick == ref_len) begin ref_e = 1; ref_tick = 0; end
      end
    end
  end

  // per-cycle comparison, a quarter period after the edge
  int cyc = 0, fb_last = 0, fb_gap = 0, ref_last = 0, ref_gap = 0;
  always @(posedge clk) begin
    #5;
    cyc++;
    if (rst_ni && !done) begin
      int exp_ld;
      case (test_code_i)
        3'd0, 3'd4: exp_ld = (hits == LOCKN);
        3'd1, 3'd5: exp_ld = ftog;
        3'd2, 3'd6: exp_ld = rcnt % 2;
        3'd3:       exp_ld = (rcnt >> 8) % 2;
        default:    exp_ld = ref_e;
      endcase
      check("R1 fb_pulse_o", fb_pulse_o, fb_e);
      check("R3 ref_pulse_o", ref_pulse_o, ref_e);
      if (test_code_i[1:0] == 2'd0) check("R5/R6/R7 ld_o lock", ld_o, exp_ld);
      else if (!test_code_i[2])     check("R8 ld_o test", ld_o, exp_ld);
      else                          check("R9 ld_o test", ld_o, exp_ld);
      check("R9 cp_hiz_o", cp_hiz_o, test_code_i[2]);
      if (fb_pulse_o)  begin fb_gap = cyc - fb_last;   fb_last = cyc;  end
      if (ref_pulse_o) begin ref_gap = cyc - ref_last; ref_last = cyc; end
    end
  end

  // stimulus
  int ref_per = 427, ph = 1;
  bit rnd = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rnd) begin
        vco_en_i = lfsr[3];
        ref_en_i = lfsr[7] & lfsr[1];
      end else begin
        vco_en_i = 1'b1;
        if (ref_per <= 1) ref_en_i = 1'b1;
        else begin
          ref_en_i = (ph == 0);
          ph = (ph + 1) % ref_per;
        end
      end
    end
  endtask

  task automatic hold_ref(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_en_i = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 fb_pulse_o in reset", fb_pulse_o, 0);
    check("R10 ref_pulse_o in reset", ref_pulse_o, 0);
    check("R10 ld_o in reset", ld_o, 0);
    check("R10 cp_hiz_o mode 0", cp_hiz_o, 0);
    main_code_i = 3'd0; swallow_code_i = 5'd1; ref_code_i = 2'd0;
    vco_en_i = 1'b1;
    rst_ni = 1'b1;

    // ratio 1281 against reference 3*427, ref one cycle late
    step(10 * 1281);
    check("R6 no lock before 16 hits", ld_o, 0);
    step(9 * 1281);
    check("R6 lock after 16 hits", ld_o, 1);
    check("R1 fb interval 1281", fb_gap, 1281);

    // ref moved to 11 cycles late
    hold_ref(10);
    step(3 * 1281);
    check("R7 lock cleared by miss", ld_o, 0);

    // ref 4 cycles late: window edge
    ph = (ph + 7) % ref_per;
    step(19 * 1281);
    check("R5 hit at +4 locks", ld_o, 1);
    // ref 5 cycles late: outside
    hold_ref(1);
    step(3 * 1281);
    check("R5 miss at +5 unlocks", ld_o, 0);
    // ref 4 cycles early
    ph = (ph + 9) % ref_per;
    step(19 * 1281);
    check("R5 hit at -4 locks", ld_o, 1);

    // mid-period code change
    step(600);
    main_code_i = 3'd7; swallow_code_i = 5'd31;
    step(3 * 1535 + 800);
    check("R2 new ratio 1535 after boundary", fb_gap, 1535);

    // test selector with a reference tick every cycle
    ref_per = 1;
    for (int tc = 1; tc < 8; tc++) begin
      test_code_i = 3'(tc);
      step(1);
      if (tc < 4) check("R8 cp_hiz_o low", cp_hiz_o, 0);
      else        check("R9 cp_hiz_o high", cp_hiz_o, 1);
      step(2000);
    end
    test_code_i = 3'd0;

    // reference ratios
    ref_code_i = 2'd3; step(40); check("R3 ratio 8", ref_gap, 8);
    ref_code_i = 2'd2; step(40); check("R3 ratio 6", ref_gap, 6);
    ref_code_i = 2'd1; step(40); check("R3 ratio 4", ref_gap, 4);
    ref_code_i = 2'd0; step(40); check("R3 ratio 3", ref_gap, 3);

    // gated ticks
    rnd = 1;
    main_code_i = 3'd2; swallow_code_i = 5'd9;
    step(12000);
    rnd = 0;
    check("R4 gated run compared per cycle", int'(errors == 0), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule